// File: doc/BRIEF.md
# Cascaded serial output turn controller

This block sits at the serial output of a parallel-in, serial-out FIFO. It lets several such FIFOs share one serial data line and one shift enable. Each device serializes whole words. A device drives the shared line only while it has the turn. When it reaches its last bit, it raises a one-shift token on its turn-out. The next device in the ring picks up the token and puts out bit 0 on the very next shift, so the combined stream has no gap and no overlap. Width expansion joins the words of several devices into one wider serial word. Depth expansion reads words back in round-robin order across the devices.

Two inputs set the role of each device, and both are captured only while reset is held. The first-load input, when low, marks the lead device, which owns the first turn. A turn-in held high during reset selects single mode. In single mode the device keeps the turn permanently. Its turn-out then carries an almost-empty/almost-full flag from the storage side, and its data driver stays enabled once the first word has been loaded. The block asks the storage for a word through a load request. It captures the word and the shift direction on the same clock edge.

Top module: `cascade_ser_ctrl`

## Requirements
- R1: The first-load and turn-in inputs are captured only while rst_n is low. Changing them after reset alters neither single_mode_o, nor the turn-out behaviour, nor which device leads.
- R2: A device whose turn-in is high during reset reports single_mode_o = 1. A device whose turn-in is low reports 0. After reset, ser_oe_o, load_req_o and, in chain mode, turn_out_o are all 0.
- R3: In single mode, turn_out_o follows almost_flag_i.
- R4: In chain mode, turn_out_o is high exactly while the device presents its last bit (bit WORD_W-1 of the shift order). It falls after the shift that consumes that bit.
- R5: On the shift that consumes a device's last bit, the next device, which has turn_in_i high, loads a word if one is available and presents its bit 0 right after. A two-device ring therefore emits a 32-bit word as one continuous run of 32 shifts.
- R6: In chain mode, ser_oe_o is high only from the load edge until the shift that consumes the last bit. Among ring members at most one drives at a time.
- R7: After reset, the device with first-load low takes the first turn, and every other device waits for the token.
- R8: A device that holds the turn with no word available keeps ser_oe_o low, keeps turn_out_o low and holds the token until a word arrives. Meanwhile, other devices that have words stay idle.
- R9: msb_first_i is captured with each word at load. 0 sends bit 0 first, and 1 sends bit WORD_W-1 first.
- R10: In single mode, words follow back to back without a gap. After the first load, ser_oe_o stays high and ser_o holds the last bit sent while no word is available.
- R11: load_req_o pulses on an edge only when shift_en_i and word_avail_i are both high and the device owns the next slot. Each pulse takes exactly one word.
- R12: The shift state advances only on clock edges with shift_en_i high. Otherwise ser_o and ser_oe_o hold.
- R13: In a three-device depth ring, words written in ring order come out whole and in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; role inputs are captured while low |
| first_load_i | input | 1 | Low at reset marks the lead device |
| turn_in_i | input | 1 | Token from the previous device; high during reset selects single mode |
| shift_en_i | input | 1 | Shared shift enable; one bit moves per enabled edge |
| word_avail_i | input | 1 | Storage has a word ready |
| word_i | input | WORD_W | Word to serialize |
| msb_first_i | input | 1 | Shift order captured at load: 0 bit 0 first, 1 top bit first |
| almost_flag_i | input | 1 | Almost-empty/almost-full flag routed out in single mode |
| load_req_o | output | 1 | Word taken from storage on this edge |
| ser_o | output | 1 | Serial data bit |
| ser_oe_o | output | 1 | Drive enable for the shared serial line |
| turn_out_o | output | 1 | Token to the next device, or the almost flag in single mode |
| single_mode_o | output | 1 | Device runs in single mode |

## Verification
The bench drives the hand-over edge directly. A two-device ring must emit each 32-bit word in exactly 32 consecutive shifts. A design that idles for a shift or waits for the token before loading stretches the run, and a design that loads early drives while the previous device is still on the line. A depth ring is starved so that one device sits on the token while the next device already has a word. A design that passes the token on without a word, or that lets a device without the token load, puts words out of order or enables two drivers at once. The role inputs are inverted after reset, and the shift direction changes between words. A design that samples these continuously then changes lead, mode or bit order. Random gaps in the shift enable show any design that advances without it.

// File: rtl/ser_cascade_pkg.sv
package ser_cascade_pkg;

  typedef enum logic {
    LINK_CHAIN  = 1'b0,
    LINK_SINGLE = 1'b1
  } link_mode_e;

  typedef enum logic {
    ROLE_LEAD   = 1'b0,
    ROLE_FOLLOW = 1'b1
  } ring_role_e;

  localparam int unsigned DEF_WORD_W = 16;

endpackage

// File: rtl/ser_cfg_capture.sv
module ser_cfg_capture
  import ser_cascade_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       first_load_i,
  input  logic       turn_in_i,
  output link_mode_e mode_o,
  output ring_role_e role_o
);

  link_mode_e mode_q, mode_d;
  ring_role_e role_q, role_d;
  logic       cap_en;

  // capture enable: only while reset is applied
  assign cap_en = ~rst_n;

  always_comb begin
    mode_d = turn_in_i    ? LINK_SINGLE : LINK_CHAIN;
    role_d = first_load_i ? ROLE_FOLLOW : ROLE_LEAD;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      mode_q <= mode_d;
      role_q <= role_d;
    end
  end

  assign mode_o = mode_q;
  assign role_o = role_q;

endmodule

// File: rtl/ser_turn_ctrl.sv
module ser_turn_ctrl
  import ser_cascade_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  link_mode_e mode_i,
  input  ring_role_e role_i,
  input  logic       shift_en_i,
  input  logic       word_avail_i,
  input  logic       turn_in_i,
  output logic       load_o,
  output logic       advance_o,
  output logic       active_o,
  output logic       last_o,
  output logic       ever_o
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic             seed_q,   seed_d;
  logic             turn_q,   turn_d;
  logic             active_q, active_d;
  logic             ever_q,   ever_d;
  logic [CNT_W-1:0] cnt_q,    cnt_d;

  logic is_single, is_lead, last_bit, owns, load, advance;

  always_comb begin
    is_single = (mode_i == LINK_SINGLE);
    is_lead   = (role_i == ROLE_LEAD);
    last_bit  = active_q && (cnt_q == LAST_IDX);
    // owns the next word slot: held token that is free or finishing,
    // or a token arriving from the previous device in the ring
    owns      = (turn_q && (!active_q || last_bit)) || (!is_single && turn_in_i);
    load      = shift_en_i && word_avail_i && owns;
    advance   = shift_en_i && active_q && !last_bit && !load;
  end

  always_comb begin
    seed_d   = 1'b0;
    turn_d   = turn_q;
    active_d = active_q;
    ever_d   = ever_q;
    cnt_d    = cnt_q;
    if (seed_q && (is_single || is_lead)) begin
      turn_d = 1'b1;
    end
    if (shift_en_i) begin
      if (load) begin
        active_d = 1'b1;
        cnt_d    = '0;
        turn_d   = is_single;
        ever_d   = 1'b1;
      end else begin
        if (advance)  cnt_d    = cnt_q + 1'b1;
        if (last_bit) active_d = 1'b0;
        if (owns)     turn_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q   <= 1'b1;
      turn_q   <= 1'b0;
      active_q <= 1'b0;
      ever_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      seed_q   <= seed_d;
      turn_q   <= turn_d;
      active_q <= active_d;
      ever_q   <= ever_d;
      cnt_q    <= cnt_d;
    end
  end

  assign load_o    = load;
  assign advance_o = advance;
  assign active_o  = active_q;
  assign last_o    = last_bit;
  assign ever_o    = ever_q;

endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter
  import ser_cascade_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              msb_first_i,
  output logic              ser_o
);

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              dir_q,  dir_d;
  logic [WORD_W-1:0] toward_top, toward_low;

  generate
    if (WORD_W > 1) begin : g_wide
      assign toward_top = {sreg_q[WORD_W-2:0], 1'b0};
      assign toward_low = {1'b0, sreg_q[WORD_W-1:1]};
    end else begin : g_bit
      assign toward_top = '0;
      assign toward_low = '0;
    end
  endgenerate

  always_comb begin
    sreg_d = sreg_q;
    dir_d  = dir_q;
    if (load_i) begin
      sreg_d = word_i;
      dir_d  = msb_first_i;
    end else if (advance_i) begin
      sreg_d = dir_q ? toward_top : toward_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      dir_q  <= dir_d;
    end
  end

  assign ser_o = dir_q ? sreg_q[WORD_W-1] : sreg_q[0];

endmodule

// File: rtl/cascade_ser_ctrl.sv
module cascade_ser_ctrl
  import ser_cascade_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_load_i,
  input  logic              turn_in_i,
  input  logic              shift_en_i,
  input  logic              word_avail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              msb_first_i,
  input  logic              almost_flag_i,
  output logic              load_req_o,
  output logic              ser_o,
  output logic              ser_oe_o,
  output logic              turn_out_o,
  output logic              single_mode_o
);

  link_mode_e mode;
  ring_role_e role;
  logic       load, advance, active, last_bit, ever;
  logic       is_single;

  ser_cfg_capture u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .first_load_i (first_load_i),
    .turn_in_i    (turn_in_i),
    .mode_o       (mode),
    .role_o       (role)
  );

  ser_turn_ctrl #(.WORD_W(WORD_W)) u_turn (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .role_i       (role),
    .shift_en_i   (shift_en_i),
    .word_avail_i (word_avail_i),
    .turn_in_i    (turn_in_i),
    .load_o       (load),
    .advance_o    (advance),
    .active_o     (active),
    .last_o       (last_bit),
    .ever_o       (ever)
  );

  ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .advance_i   (advance),
    .word_i      (word_i),
    .msb_first_i (msb_first_i),
    .ser_o       (ser_o)
  );

  assign is_single     = (mode == LINK_SINGLE);
  assign single_mode_o = is_single;
  assign load_req_o    = load;
  // single mode keeps driving the last bit once a word has gone out
  assign ser_oe_o      = active || (is_single && ever);
  assign turn_out_o    = is_single ? almost_flag_i : last_bit;

endmodule

// File: rtl/cascade_ser_ctrl_checker.sv
module cascade_ser_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic shift_en_i,
  input logic word_avail_i,
  input logic load_req_o,
  input logic ser_o,
  input logic ser_oe_o,
  input logic turn_out_o,
  input logic single_mode_o
);

  assert_load_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |-> (shift_en_i && word_avail_i));

  assert_drive_after_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |=> ser_oe_o);

  assert_token_one_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_mode_o && turn_out_o && shift_en_i) |=> !turn_out_o);

  assert_token_while_driving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_mode_o && turn_out_o) |-> ser_oe_o);

  assert_hold_without_shift_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe_o && !shift_en_i) |=> (ser_oe_o && $stable(ser_o)));

  assert_mode_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(single_mode_o));

  assert_single_keeps_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode_o && ser_oe_o) |=> ser_oe_o);

endmodule

bind cascade_ser_ctrl cascade_ser_ctrl_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .shift_en_i    (shift_en_i),
  .word_avail_i  (word_avail_i),
  .load_req_o    (load_req_o),
  .ser_o         (ser_o),
  .ser_oe_o      (ser_oe_o),
  .turn_out_o    (turn_out_o),
  .single_mode_o (single_mode_o)
);

// File: tb/tb_cascade_ser_ctrl.sv
`timescale 1ns/1ps
module tb_cascade_ser_ctrl;

  localparam int W  = 16;
  localparam int ND = 6; // 0 single, 1-2 width ring, 3-5 depth ring

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          se = 1'b0;
  logic          gap_mode = 1'b0;
  logic [7:0]    lfsr = 8'h5b;
  logic          almost = 1'b0;
  logic          fl   [ND];
  logic          msb  [ND];
  logic          tin0 = 1'b1;
  logic          src_avail [ND];
  logic [W-1:0]  src_word  [ND];
  logic          ser  [ND];
  logic          oe   [ND];
  logic          tout [ND];
  logic          sng  [ND];
  logic          lreq [ND];
  logic          popf [ND];
  int            rem  [ND];
  logic [W-1:0]  srcq [ND][$];
  logic          expq [3][$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_on = 1'b0;
  int first_cyc = -1, last_cyc = -1, first_dev = -1;
  int tpulse [ND];
  int depth_drive = 0;

  initial begin
    for (int i = 0; i < ND; i++) begin
      fl[i] = 1'b1; msb[i] = 1'b0; src_avail[i] = 1'b0; src_word[i] = '0;
      popf[i] = 1'b0; rem[i] = 0; tpulse[i] = 0;
    end
    fl[1] = 1'b0; fl[3] = 1'b0;
  end

  cascade_ser_ctrl #(.WORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .first_load_i(fl[0]), .turn_in_i(tin0),
    .shift_en_i(se), .word_avail_i(src_avail[0]), .word_i(src_word[0]),
    .msb_first_i(msb[0]), .almost_flag_i(almost), .load_req_o(lreq[0]),
    .ser_o(ser[0]), .ser_oe_o(oe[0]), .turn_out_o(tout[0]), .single_mode_o(sng[0]));

  cascade_ser_ctrl #(.WORD_W(W)) u_wa (
    .clk(clk), .rst_n(rst_n), .first_load_i(fl[1]), .turn_in_i(tout[2]),
    .shift_en_i(se), .word_avail_i(src_avail[1]), .word_i(src_word[1]),
    .msb_first_i(msb[1]), .almost_flag_i(almost), .load_req_o(lreq[1]),
    .ser_o(ser[1]), .ser_oe_o(oe[1]), .turn_out_o(tout[1]), .single_mode_o(sng[1]));

  cascade_ser_ctrl #(.WORD_W(W)) u_wb (
    .clk(clk), .rst_n(rst_n), .first_load_i(fl[2]), .turn_in_i(tout[1]),
    .shift_en_i(se), .word_avail_i(src_avail[2]), .word_i(src_word[2]),
    .msb_first_i(msb[2]), .almost_flag_i(almost), .load_req_o(lreq[2]),
    .ser_o(ser[2]), .ser_oe_o(oe[2]), .turn_out_o(tout[2]), .single_mode_o(sng[2]));

  cascade_ser_ctrl #(.WORD_W(W)) u_d0 (
    .clk(clk), .rst_n(rst_n), .first_load_i(fl[3]), .turn_in_i(tout[5]),
    .shift_en_i(se), .word_avail_i(src_avail[3]), .word_i(src_word[3]),
    .msb_first_i(msb[3]), .almost_flag_i(almost), .load_req_o(lreq[3]),
    .ser_o(ser[3]), .ser_oe_o(oe[3]), .turn_out_o(tout[3]), .single_mode_o(sng[3]));

  cascade_ser_ctrl #(.WORD_W(W)) u_d1 (
    .clk(clk), .rst_n(rst_n), .first_load_i(fl[4]), .turn_in_i(tout[3]),
    .shift_en_i(se), .word_avail_i(src_avail[4]), .word_i(src_word[4]),
    .msb_first_i(msb[4]), .almost_flag_i(almost), .load_req_o(lreq[4]),
    .ser_o(ser[4]), .ser_oe_o(oe[4]), .turn_out_o(tout[4]), .single_mode_o(sng[4]));

  cascade_ser_ctrl #(.WORD_W(W)) u_d2 (
    .clk(clk), .rst_n(rst_n), .first_load_i(fl[5]), .turn_in_i(tout[4]),
    .shift_en_i(se), .word_avail_i(src_avail[5]), .word_i(src_word[5]),
    .msb_first_i(msb[5]), .almost_flag_i(almost), .load_req_o(lreq[5]),
    .ser_o(ser[5]), .ser_oe_o(oe[5]), .turn_out_o(tout[5]), .single_mode_o(sng[5]));

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // driver: word into a device source, and its bits into the scoreboard
  task automatic push_src(input int dev, input logic [W-1:0] w);
    srcq[dev].push_back(w);
  endtask

  task automatic push_exp(input int g, input logic [W-1:0] w, input bit top_first);
    for (int b = 0; b < W; b++) expq[g].push_back(top_first ? w[W-1-b] : w[b]);
  endtask

  task automatic mon_group(input int g, input int lo, input int hi, input string req);
    logic bus;
    bit   busy;
    int   who;
    bus = 1'b0; busy = 1'b0; who = -1;
    for (int i = lo; i <= hi; i++) begin
      if (oe[i]) bus = bus | ser[i];
      if (rem[i] > 0) begin busy = 1'b1; who = i; end
    end
    if (busy) begin
      if (g == 1 && first_dev < 0) first_dev = who;
      if (g == 1) begin
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
      end
      if (expq[g].size() == 0) begin
        check(1'b0, req, "unexpected bit", int'(bus), -1);
      end else begin
        check(bus === expq[g][0], req, "serial bit", int'(bus), int'(expq[g][0]));
        expq[g].delete(0);
      end
    end
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < ND; i++) begin
      popf[i] <= lreq[i];
      if (lreq[i]) rem[i] <= W;
      else if (se && rem[i] > 0) rem[i] <= rem[i] - 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < ND; i++) begin
      if (popf[i] && srcq[i].size() > 0) srcq[i].delete(0);
      src_avail[i] = (srcq[i].size() > 0);
      src_word[i]  = (srcq[i].size() > 0) ? srcq[i][0] : '0;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    se   = gap_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (rst_n && mon_on) begin
      for (int i = 1; i < ND; i++) begin
        check(oe[i] === (rem[i] > 0), "R6", $sformatf("oe dev%0d", i), int'(oe[i]), int'(rem[i] > 0));
        check(tout[i] === (rem[i] == 1), "R4", $sformatf("token dev%0d", i), int'(tout[i]), int'(rem[i] == 1));
        if (tout[i] && se) tpulse[i]++;
      end
      if (oe[3] || oe[4] || oe[5]) depth_drive++;
      if (se) begin
        mon_group(0, 0, 0, "R9");
        mon_group(1, 1, 2, "R5");
        mon_group(2, 3, 5, "R13");
      end
    end
  end

  task automatic drain(input int g);
    while (expq[g].size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #80000;
    fails++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ww [3];
    logic [W-1:0] dw;
    ww[0] = 32'hDEAD_BEEF; ww[1] = 32'h0123_4567; ww[2] = 32'hF00F_A55A;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R2
    check(sng[0] === 1'b1, "R2", "single dut mode", int'(sng[0]), 1);
    for (int i = 1; i < ND; i++) begin
      check(sng[i] === 1'b0, "R2", "chain mode", int'(sng[i]), 0);
      check(tout[i] === 1'b0, "R2", "token after reset", int'(tout[i]), 0);
    end
    for (int i = 0; i < ND; i++) begin
      check(oe[i] === 1'b0, "R2", "oe after reset", int'(oe[i]), 0);
      check(lreq[i] === 1'b0, "R2", "load_req after reset", int'(lreq[i]), 0);
    end

    // R1: invert role inputs after reset
    tin0 = 1'b0; fl[1] = 1'b1; fl[2] = 1'b0; fl[3] = 1'b1; fl[5] = 1'b0;
    @(negedge clk);
    check(sng[0] === 1'b1, "R1", "mode after turn-in change", int'(sng[0]), 1);
    // R3 flag routing
    almost = 1'b1;
    @(negedge clk);
    check(tout[0] === 1'b1, "R3", "flag high", int'(tout[0]), 1);
    almost = 1'b0;
    @(negedge clk);
    check(tout[0] === 1'b0, "R3", "flag low", int'(tout[0]), 0);
    check(oe[0] === 1'b0, "R10", "single oe before first load", int'(oe[0]), 0);
    mon_on = 1'b1;

    // single device, LSB first then MSB first (R9, R10)
    push_exp(0, 16'hA5C3, 1'b0); push_src(0, 16'hA5C3);
    push_exp(0, 16'h1234, 1'b0); push_src(0, 16'h1234);
    // width ring, continuous shifting (R5, R7)
    for (int k = 0; k < 3; k++) begin
      push_src(1, ww[k][15:0]); push_src(2, ww[k][31:16]);
      for (int b = 0; b < 32; b++) expq[1].push_back(ww[k][b]);
    end
    drain(0);
    drain(1);
    check(last_cyc - first_cyc == 95, "R5", "width run span", last_cyc - first_cyc, 95);
    check(first_dev == 1, "R7", "first driver", first_dev, 1);
    check(tpulse[1] == 3, "R4", "tokens from lead", tpulse[1], 3);
    check(tpulse[2] == 3, "R4", "tokens from second", tpulse[2], 3);

    msb[0] = 1'b1;
    @(negedge clk);
    push_exp(0, 16'h8001, 1'b1); push_src(0, 16'h8001);
    push_exp(0, 16'h3C0F, 1'b1); push_src(0, 16'h3C0F);
    drain(0);
    repeat (5) @(negedge clk);
    check(oe[0] === 1'b1, "R10", "single keeps drive", int'(oe[0]), 1);
    check(ser[0] === 1'b1, "R10", "single retains last bit", int'(ser[0]), 1);
    almost = 1'b1;
    @(negedge clk);
    check(tout[0] === 1'b1, "R1", "flag route after turn-in change", int'(tout[0]), 1);

    // depth ring with shift gaps (R12, R13)
    gap_mode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      dw = 16'h1357 ^ (16'h0F1E * 16'(k + 1));
      push_src(3 + (k % 3), dw); push_exp(2, dw, 1'b0);
    end
    drain(2);
    // leave the token parked at the third device (R8)
    push_src(3, 16'h4444); push_exp(2, 16'h4444, 1'b0);
    push_src(4, 16'h5555); push_exp(2, 16'h5555, 1'b0);
    drain(2);
    push_src(3, 16'h6666);
    depth_drive = 0;
    repeat (40) @(negedge clk);
    check(depth_drive == 0, "R8", "drive while token starved", depth_drive, 0);
    check(srcq[3].size() == 1, "R8", "lead word untouched", srcq[3].size(), 1);
    push_src(5, 16'h7777); push_exp(2, 16'h7777, 1'b0);
    push_exp(2, 16'h6666, 1'b0);
    push_src(4, 16'h8888); push_exp(2, 16'h8888, 1'b0);
    drain(2);
    for (int i = 0; i < ND; i++)
      check(srcq[i].size() == 0, "R11", $sformatf("words left dev%0d", i), srcq[i].size(), 0);
    check(expq[0].size() + expq[1].size() == 0, "R12", "bits left", expq[0].size() + expq[1].size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule